// File: doc/BRIEF.md
# Weighted Round Robin Arbiter with Urgent Class

This block decides, each clock cycle, which of `NQ` command submission queues may issue its next command. Every queue raises a request bit while it holds work and carries a 2-bit class code. Class 00 is Urgent, 01 is High, 10 is Medium and 11 is Low. Queue 0 is the admin queue and counts as Urgent whatever its code says.

Arbitration has two levels. Urgent requests always win outright. When no Urgent request is present, High, Medium and Low share the grants through per-class credits. A class holds weight+1 credits per round, and each weight is an 8-bit value from 0 to 255. Inside a round, High is served first, then Medium, then Low, and each grant costs the granted class one credit. A class with no requesting queue keeps its credits. When every weighted class that is requesting has run out of credits, all three are refilled from the weights, and the refill takes effect in that same cycle. Inside each class, a rotating pointer makes the queues take turns.

The grant is combinational from the inputs and the stored state. State (credits and pointers) advances on the clock edge that ends the cycle of the grant. The grant is meant to be consumed in the cycle it is shown.

Top module: `wrr_urgent_arb`

## Requirements
- R1: `grant` has at most one bit set. `grant_valid` is high exactly when `req` has any bit set. After reset with no requests, both outputs are zero.
- R2: A granted queue always has its request bit set in the same cycle.
- R3: If any queue of class 00 (Urgent) requests, the grant goes to an Urgent queue, whatever the other classes request or what credits they hold.
- R4: Queue 0 is treated as Urgent even when its class field (`qclass[1:0]`) holds 01, 10 or 11.
- R5: Within a class, the next grant goes to the first requesting queue of that class above the last one granted in that class, wrapping from NQ-1 to 0. After reset each class starts its search at queue 0.
- R6: Suppose classes 01 (High), 10 (Medium) and 11 (Low) all request continuously with no Urgent request. Each round then grants High weight+1 times, then Medium weight+1 times, then Low weight+1 times, in that order.
- R7: A weighted class with no requesting queue is skipped and keeps its remaining credits. When every requesting weighted class has zero credits, all credits are refilled in that same cycle and a grant is still issued.
- R8: Cycles with an Urgent grant leave the weighted credits unchanged.
- R9: A weight of 0 gives its class exactly one grant per round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NQ | Per-queue request; high while the queue holds a command |
| qclass | input | 2*NQ | Class code of queue i in bits [2i+1:2i]; 00 Urgent, 01 High, 10 Medium, 11 Low |
| wgt_high | input | WW | Weight of class High |
| wgt_med | input | WW | Weight of class Medium |
| wgt_low | input | WW | Weight of class Low |
| grant | output | NQ | One-hot grant to the chosen queue |
| grant_valid | output | 1 | High when a grant is issued this cycle |

## Verification
The bench runs a four-queue build. It sweeps every request pattern against every class assignment while a reference model tracks credits and pointers.

Several errors would each show up as a wrong grant sequence:
- A refill delayed by one cycle would produce a cycle with requests but no grant.
- Credits consumed during Urgent cycles would shorten the High run that follows.
- A pointer that restarts from queue 0 would starve the upper queues of a class.
- A class field honoured on queue 0 would let a weighted queue overtake the admin queue.

Directed runs count grants over whole rounds to confirm the weight+1 ratios, including a weight of zero.

// File: rtl/wrr_pkg.sv
// Shared class codes and sizes for the weighted urgent arbiter.
// Assumes four classes; the class code values are part of the port contract.
package wrr_pkg;
    typedef enum logic [1:0] {
        CLS_URG  = 2'b00,
        CLS_HIGH = 2'b01,
        CLS_MED  = 2'b10,
        CLS_LOW  = 2'b11
    } wrr_cls_e;

    localparam int NUM_CLS  = 4;
    localparam int NUM_WCLS = 3;
endpackage

// File: rtl/wrr_class_map.sv
// Splits the request vector into one request vector per class.
// Assumes queue 0 is the admin queue and forces it into the Urgent class.
module wrr_class_map #(
    parameter int NQ = 8
) (
    input  logic [NQ-1:0]                   req,
    input  logic [2*NQ-1:0]                 qclass,
    output logic [wrr_pkg::NUM_CLS-1:0][NQ-1:0] cls_req
);
    import wrr_pkg::*;

    for (genvar i = 0; i < NQ; i++) begin : g_queue
        wrr_cls_e eff_cls;
        // effective class: admin queue is pinned to Urgent
        always_comb begin
            if (i == 0) eff_cls = CLS_URG;
            else        eff_cls = wrr_cls_e'(qclass[2*i +: 2]);
        end
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
            assign cls_req[c][i] = req[i] && (eff_cls == wrr_cls_e'(c));
        end
    end
endmodule

// File: rtl/wrr_rr_pick.sv
// Round-robin picker for one class: chooses the first requester above the
// last granted index, wrapping. The pointer moves only when this class wins.
// Assumes NQ >= 2.
module wrr_rr_pick #(
    parameter int NQ = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] req,
    input  logic          adv,
    output logic [NQ-1:0] pick,
    output logic          any
);
    localparam int IW = $clog2(NQ);

    logic [IW-1:0] ptr;
    logic [IW-1:0] win_idx;

    // scan from ptr+1 upward with wrap, keep the first requester
    always_comb begin
        pick    = '0;
        any     = 1'b0;
        win_idx = ptr;
        for (int off = 1; off <= NQ; off++) begin
            int idx;
            idx = (int'(ptr) + off) % NQ;
            if (!any && req[idx]) begin
                pick[idx] = 1'b1;
                any       = 1'b1;
                win_idx   = IW'(idx);
            end
        end
    end

    // remember the last granted queue of this class
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr <= IW'(NQ - 1);
        else if (adv && any) ptr <= win_idx;
    end

    a_r5_pick_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((pick & ~req) == '0) && $onehot0(pick));
    a_r5_pick_when_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> $onehot(pick));
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/wrr_credit.sv
// Credit bank for the three weighted classes (index 0 High, 1 Medium, 2 Low).
// Picks the highest-order eligible class; refills all credits to weight+1
// in the same cycle when no requesting class has credit left.
// Credits are untouched while an Urgent request is present.
module wrr_credit #(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] wgt_high,
    input  logic [WW-1:0] wgt_med,
    input  logic [WW-1:0] wgt_low,
    input  logic [2:0]    cls_any,
    input  logic          urg_any,
    output logic [2:0]    sel
);
    localparam int CW = WW + 1;
    localparam logic [CW-1:0] CMAX = CW'(1) << WW;

    logic [2:0][CW-1:0] cred;
    logic [2:0][CW-1:0] full;
    logic [2:0][CW-1:0] eff;
    logic [2:0]         nz;
    logic [2:0]         elig;
    logic               refill;

    // refill values are weight+1 per class
    always_comb begin
        full[0] = {1'b0, wgt_high} + CW'(1);
        full[1] = {1'b0, wgt_med}  + CW'(1);
        full[2] = {1'b0, wgt_low}  + CW'(1);
    end

    // decide refill and which credits apply this cycle
    always_comb begin
        for (int k = 0; k < 3; k++) nz[k] = (cred[k] != '0);
        refill = (|cls_any) && !(|(cls_any & nz));
        for (int k = 0; k < 3; k++) eff[k] = refill ? full[k] : cred[k];
    end

    // fixed order within a round: High, then Medium, then Low
    always_comb begin
        for (int k = 0; k < 3; k++) elig[k] = cls_any[k] && (eff[k] != '0);
        sel = '0;
        if (!urg_any) begin
            if (elig[0])      sel = 3'b001;
            else if (elig[1]) sel = 3'b010;
            else if (elig[2]) sel = 3'b100;
        end
    end

    // charge one credit to the served class, commit any refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred <= '0;
        end else if (!urg_any && (|elig)) begin
            for (int k = 0; k < 3; k++)
                cred[k] <= eff[k] - (sel[k] ? CW'(1) : CW'(0));
        end
    end

    a_r8_urgent_hold: assert property (@(posedge clk) disable iff (!rst_n)
        urg_any |=> $stable(cred));
    a_r7_grant_if_any: assert property (@(posedge clk) disable iff (!rst_n)
        (!urg_any && (|cls_any)) |-> $onehot(sel));
    for (genvar k = 0; k < 3; k++) begin : g_chk
        a_r6_cred_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cred[k] <= CMAX);
        a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!cls_any[k] && !refill) |=> $stable(cred[k]));
    end
endmodule

// File: rtl/wrr_urgent_arb.sv
// Two-level queue arbiter: Urgent class has strict priority, the other three
// classes share grants by weighted credits, round robin inside each class.
// Output is combinational from inputs and state; state advances at the edge.
module wrr_urgent_arb #(
    parameter int NQ = 8,
    parameter int WW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NQ-1:0]   req,
    input  logic [2*NQ-1:0] qclass,
    input  logic [WW-1:0]   wgt_high,
    input  logic [WW-1:0]   wgt_med,
    input  logic [WW-1:0]   wgt_low,
    output logic [NQ-1:0]   grant,
    output logic            grant_valid
);
    import wrr_pkg::*;

    logic [NUM_CLS-1:0][NQ-1:0] cls_req;
    logic [NUM_CLS-1:0][NQ-1:0] cls_pick;
    logic [NUM_CLS-1:0]         cls_any;
    logic [NUM_CLS-1:0]         cls_win;
    logic [2:0]                 wsel;

    wrr_class_map #(.NQ(NQ)) u_map (
        .req     (req),
        .qclass  (qclass),
        .cls_req (cls_req)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_rr
        wrr_rr_pick #(.NQ(NQ)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (cls_req[c]),
            .adv   (cls_win[c]),
            .pick  (cls_pick[c]),
            .any   (cls_any[c])
        );
    end

    wrr_credit #(.WW(WW)) u_cred (
        .clk      (clk),
        .rst_n    (rst_n),
        .wgt_high (wgt_high),
        .wgt_med  (wgt_med),
        .wgt_low  (wgt_low),
        .cls_any  (cls_any[3:1]),
        .urg_any  (cls_any[0]),
        .sel      (wsel)
    );

    // winning class: Urgent first, otherwise the credit bank's choice
    always_comb begin
        cls_win = {wsel, cls_any[0]};
    end

    // route the winning class's pick to the grant
    always_comb begin
        grant = '0;
        for (int c = 0; c < NUM_CLS; c++)
            if (cls_win[c]) grant = cls_pick[c];
        grant_valid = |grant;
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == ($countones(grant) == 1)));
    a_r1_valid_iff_req: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (|req));
    a_r2_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    a_r3_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|cls_req[0]) |-> ((grant & cls_req[0]) != '0));
    a_r4_admin_urgent: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0] && (req[NQ-1:1] == '0)) |-> grant[0]);
endmodule

// File: tb/tb_wrr_urgent_arb.sv
// Bench: four-queue build, full sweep of request x class patterns against a
// reference model of credits and pointers, plus directed round counts.
module tb_wrr_urgent_arb;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 4;
    localparam int WW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NQ-1:0]   req = '0;
    logic [2*NQ-1:0] qclass = '0;
    logic [WW-1:0]   wgt_high = '0, wgt_med = '0, wgt_low = '0;
    logic [NQ-1:0]   grant;
    logic            grant_valid;

    int n_chk = 0;
    int n_fail = 0;
    int m_ptr [4];
    int m_cred[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    wrr_urgent_arb #(.NQ(NQ), .WW(WW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .qclass(qclass),
        .wgt_high(wgt_high), .wgt_med(wgt_med), .wgt_low(wgt_low),
        .grant(grant), .grant_valid(grant_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int c = 0; c < 4; c++) m_ptr[c] = NQ - 1;
        for (int k = 0; k < 3; k++) m_cred[k] = 0;
    endtask

    // drive one cycle, compare with the model, advance the model; gi = winner
    task automatic step(input logic [NQ-1:0] r, input logic [2*NQ-1:0] c,
                        input string tag, output int gi);
        int cls[NQ];
        int win_c, need, any_w;
        int eff[3];
        logic [NQ-1:0] exp_g;
        @(negedge clk);
        req = r; qclass = c;
        #1;
        for (int i = 0; i < NQ; i++) cls[i] = (i == 0) ? 0 : int'(c[2*i +: 2]);
        win_c = -1;
        for (int i = 0; i < NQ; i++) if (r[i] && cls[i] == 0) win_c = 0;
        if (win_c < 0) begin
            bit wreq[3];
            for (int k = 0; k < 3; k++) wreq[k] = 0;
            for (int i = 0; i < NQ; i++) if (r[i]) wreq[cls[i]-1] = 1;
            any_w = 0; need = 1;
            for (int k = 0; k < 3; k++) if (wreq[k]) begin
                any_w = 1;
                if (m_cred[k] > 0) need = 0;
            end
            if (any_w) begin
                eff[0] = need ? int'(wgt_high) + 1 : m_cred[0];
                eff[1] = need ? int'(wgt_med)  + 1 : m_cred[1];
                eff[2] = need ? int'(wgt_low)  + 1 : m_cred[2];
                for (int k = 2; k >= 0; k--) if (wreq[k] && eff[k] > 0) win_c = k + 1;
                for (int k = 0; k < 3; k++) m_cred[k] = eff[k] - ((win_c == k + 1) ? 1 : 0);
            end
        end
        exp_g = '0; gi = -1;
        if (win_c >= 0) begin
            for (int off = 1; off <= NQ; off++) begin
                int idx;
                idx = (m_ptr[win_c] + off) % NQ;
                if (gi < 0 && r[idx] && cls[idx] == win_c) gi = idx;
            end
            exp_g[gi] = 1'b1;
            m_ptr[win_c] = gi;
        end
        check(grant == exp_g && grant_valid == (exp_g != '0), tag,
              int'(grant), int'(exp_g));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog R1 actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int gi;
        int cnt[4];
        wgt_high = 8'd2; wgt_med = 8'd1; wgt_low = 8'd0;
        do_reset();

        // R1: idle after reset
        #1;
        check(grant == '0 && grant_valid == 1'b0, "R1 reset idle", int'(grant), 0);

        // R6 R9: High w=2, Medium w=1, Low w=0 over three rounds -> 9/6/3
        for (int q = 0; q < 4; q++) cnt[q] = 0;
        for (int n = 0; n < 18; n++) begin
            step(4'b1110, 8'b11_10_01_00, "R6 round order", gi);
            if (gi >= 0) cnt[gi]++;
        end
        check(cnt[1] == 9, "R6 high share", cnt[1], 9);
        check(cnt[2] == 6, "R6 medium share", cnt[2], 6);
        check(cnt[3] == 3, "R9 zero weight share", cnt[3], 3);

        // R5: three High queues rotate 1,2,3,1 after reset
        do_reset();
        step(4'b1110, 8'b01_01_01_00, "R5 rotate", gi); check(gi == 1, "R5 first", gi, 1);
        step(4'b1110, 8'b01_01_01_00, "R5 rotate", gi); check(gi == 2, "R5 second", gi, 2);
        step(4'b1110, 8'b01_01_01_00, "R5 rotate", gi); check(gi == 3, "R5 third", gi, 3);
        step(4'b1110, 8'b01_01_01_00, "R5 rotate", gi); check(gi == 1, "R5 wrap", gi, 1);

        // R3: Urgent queue 2 beats High queue 1
        step(4'b0110, 8'b01_00_01_00, "R3 urgent", gi); check(gi == 2, "R3 urgent wins", gi, 2);
        // R4: queue 0 with class field 11 still beats High
        step(4'b0011, 8'b01_01_01_11, "R4 admin", gi); check(gi == 0, "R4 admin wins", gi, 0);

        // R8: Urgent grant in mid-round does not cost High credit (w=1)
        wgt_high = 8'd1; wgt_med = 8'd0;
        do_reset();
        step(4'b0110, 8'b00_10_01_00, "R8 seq", gi); check(gi == 1, "R8 high1", gi, 1);
        step(4'b1110, 8'b00_10_01_00, "R8 seq", gi); check(gi == 3, "R8 urgent", gi, 3);
        step(4'b0110, 8'b00_10_01_00, "R8 seq", gi); check(gi == 1, "R8 high2 kept", gi, 1);
        step(4'b0110, 8'b00_10_01_00, "R8 seq", gi); check(gi == 2, "R8 medium", gi, 2);

        // R7: only Low requests, credits run out and refill without a gap
        do_reset();
        for (int n = 0; n < 6; n++) begin
            step(4'b1000, 8'b11_10_01_00, "R7 refill", gi);
            check(gi == 3, "R7 lone low", gi, 3);
        end

        // R1 R2 R3 R4 R5 R6 R7 R8: full sweep of requests x class codes
        wgt_high = 8'd1; wgt_med = 8'd0; wgt_low = 8'd2;
        do_reset();
        for (int r = 0; r < 16; r++)
            for (int cc = 0; cc < 256; cc++)
                step(4'(r), 8'(cc), "sweep R1 R2 R3 R4 R5 R6 R7 R8", gi);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule